// File: doc/BRIEF.md
# Interrupt Source Resend Controller

This block keeps the state of a small bank of interrupt sources and feeds them, one at a time, to a single presenter. Each source carries a priority, a target server number, an asserted flag, a resend flag and a masked-pending flag. A source asks for delivery when its line is asserted, when the presenter rejects it, when it is still asserted at end-of-interrupt, when it is unmasked with an event parked, when a scan finds its resend flag set, or when a newer delivery displaces it. The block works through these requests in ascending source index. It offers each request to the presenter over a valid/ready handshake and then waits for a one-cycle accept or refuse response.

Deliveries are never lost. A refused delivery parks the source in its resend flag and pulses a resend-map strobe toward the presenter. If the presenter reports that its own need-resend indication has already cleared, the block retries the same source straight away. A source whose priority holds the masked code records a masked-pending event instead of being offered. Interrupt numbers on the presenter side are `SRC_BASE + index`, and the code `IPI_NUM` stands for an inter-processor interrupt that this block never owns.

Top module: `isr_resend_ctrl`

## Requirements
- R1: After reset every source is masked (priority 0xFF) with all flags clear, `dlv_valid` and `rmap_set` are low, and asserting a line produces no delivery request.
- R2: A level write with `lvl_on`=1 to a source with an unmasked priority whose server equals `PRES_ID` raises `dlv_valid` on the second rising edge after the write is sampled, with `dlv_num` = `SRC_BASE` + index and `dlv_prio` = the source priority.
- R3: A delivery attempt on a source whose priority is 0xFF issues no request and sets its masked-pending flag; this also applies to attempts that come from a resend scan.
- R4: A configuration write that gives a priority other than 0xFF to a source with masked-pending set clears that flag and starts a delivery (request on the second edge); the same write with the flag clear starts nothing.
- R5: A response with `rsp_ok`=0 sets the source's resend flag and drives `rmap_set` high for exactly the one cycle after the response edge; an accepted response leaves `rmap_set` low.
- R6: When a refusal arrives with `rsp_need_resend`=0, the same source is offered again one edge after the response; with `rsp_need_resend`=1 nothing is offered until some other event asks for it.
- R7: An accepted response whose `rsp_displaced` names one of this block's sources (not 0, not `IPI_NUM`) redelivers that source, with the request on the second edge after the response; a displaced value of 0, `IPI_NUM` or a number outside the bank causes nothing.
- R8: A reject input naming one of this block's sources redelivers it, with the request on the second edge.
- R9: A scan request offers every source whose resend flag is set, in ascending index order; every attempt clears the resend flag of its source, so a second scan after all of them are accepted offers nothing.
- R10: End-of-interrupt for a source that is still asserted redelivers it; end-of-interrupt for a source that is deasserted, or for `IPI_NUM`, causes nothing.
- R11: A source whose server differs from `PRES_ID` is dropped at its attempt and offers no request.
- R12: Only one delivery is outstanding: while `dlv_valid` is high and `dlv_ready` is low, `dlv_num` and `dlv_prio` hold, and no new request is raised until the response for the current one has arrived.
- R13: When several sources are waiting at once, the lowest index is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write priority and server of one source |
| cfg_idx | input | 4 | Source index for the configuration write |
| cfg_prio | input | 8 | New priority, 0xFF = masked |
| cfg_server | input | 4 | New target server number |
| lvl_we | input | 1 | Update the asserted flag of one source |
| lvl_idx | input | 4 | Source index for the level update |
| lvl_on | input | 1 | New asserted state; 1 also requests delivery |
| rej_valid | input | 1 | Presenter rejects a previously presented interrupt |
| rej_num | input | 24 | Interrupt number that was rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | 24 | Interrupt number being completed |
| scan_req | input | 1 | Presenter asks for a resend scan |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Presenter takes the request |
| dlv_num | output | 24 | Interrupt number offered |
| dlv_prio | output | 8 | Priority offered |
| rsp_valid | input | 1 | Delivery response strobe |
| rsp_ok | input | 1 | 1 = accepted, 0 = refused |
| rsp_need_resend | input | 1 | Presenter's need-resend indication at refusal |
| rsp_displaced | input | 24 | Interrupt pushed out by an accepted delivery, 0 if none |
| rmap_set | output | 1 | One-cycle strobe: set this controller's bit in the presenter's resend map |

## Verification
Every event input is sampled on one edge, raises a wait bit on that edge, is picked on the next edge and is attempted on the edge after. A request therefore appears on the second rising edge after the stimulus, and the bench checks `dlv_valid` low after the first edge and high with the expected number and priority after the second. Responses are sampled on their own edge: `rmap_set` is checked just after it, a refusal with need-resend clear is checked for a new request one edge later, and displaced redeliveries two edges later. Cases where nothing should happen (masked sources, foreign servers, IPI completions, empty scans) are checked by watching `dlv_valid` stay low over several cycles, and parked flags are then brought out by a later unmask or scan.

// File: rtl/isr_pkg.sv
package isr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ATT,
    ST_REQ,
    ST_RSP
  } isr_state_e;

endpackage

// File: rtl/isr_num_dec.sv
module isr_num_dec #(
  parameter int NUM_W    = 24,
  parameter int N_SRC    = 16,
  parameter int SRC_BASE = 32,
  localparam int IDX_W   = $clog2(N_SRC)
) (
  input  logic [NUM_W-1:0] num,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  localparam logic [NUM_W-1:0] LO = NUM_W'(SRC_BASE);
  localparam logic [NUM_W-1:0] HI = NUM_W'(SRC_BASE + N_SRC);

  always_comb begin
    hit = (num >= LO) && (num < HI);
    idx = IDX_W'(num - LO);
  end

endmodule

// File: rtl/isr_pick.sv
module isr_pick #(
  parameter int N_SRC  = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  logic [N_SRC-1:0] below;
  logic [N_SRC-1:0] gnt;

  assign below[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < N_SRC; g++) begin : g_chain
      assign below[g] = below[g-1] | req[g-1];
    end
  endgenerate

  assign gnt = req & ~below;
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (gnt[i]) idx = idx | IDX_W'(i);
    end
  end

  // R13: the chosen index is requesting and nothing below it is
  assert_lowest_first_R13: assert property (@(posedge clk) disable iff (rst)
    any |-> (req[idx] && ((req & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0)));

endmodule

// File: rtl/isr_flagvec.sv
module isr_flagvec #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_v) | set_v;
  end

  // R9: a cleared flag with no competing set is low on the next cycle
  assert_clear_takes_R9: assert property (@(posedge clk) disable iff (rst)
    ((clr_v != '0) && (set_v == '0)) |=> ((q & $past(clr_v)) == '0));

endmodule

// File: rtl/isr_src_table.sv
module isr_src_table #(
  parameter int N_SRC     = 16,
  parameter int PRIO_W    = 8,
  parameter int SRV_W     = 4,
  parameter int MASK_PRIO = 255,
  localparam int IDX_W    = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic              lvl_we,
  input  logic [IDX_W-1:0]  lvl_idx,
  input  logic              lvl_on,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PRIO_W-1:0] rd_prio,
  output logic [SRV_W-1:0]  rd_srv,
  output logic [N_SRC-1:0]  asserted
);

  logic [PRIO_W-1:0] prio_mem [N_SRC];
  logic [SRV_W-1:0]  srv_mem  [N_SRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SRC; i++) begin
        prio_mem[i] <= PRIO_W'(MASK_PRIO);
        srv_mem[i]  <= '0;
      end
    end else if (cfg_we) begin
      prio_mem[cfg_idx] <= cfg_prio;
      srv_mem[cfg_idx]  <= cfg_server;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         asserted <= '0;
    else if (lvl_we) asserted[lvl_idx] <= lvl_on;
  end

  assign rd_prio = prio_mem[rd_idx];
  assign rd_srv  = srv_mem[rd_idx];

endmodule

// File: rtl/isr_fsm.sv
module isr_fsm
  import isr_pkg::*;
#(
  parameter int N_SRC     = 16,
  parameter int PRIO_W    = 8,
  parameter int SRV_W     = 4,
  parameter int NUM_W     = 24,
  parameter int SRC_BASE  = 32,
  parameter int IPI_NUM   = 2,
  parameter int MASK_PRIO = 255,
  parameter int PRES_ID   = 0,
  localparam int IDX_W    = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pick_any,
  input  logic [IDX_W-1:0]  pick_idx,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [PRIO_W-1:0] rd_prio,
  input  logic [SRV_W-1:0]  rd_srv,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [NUM_W-1:0]  dlv_num,
  output logic [PRIO_W-1:0] dlv_prio,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  input  logic              rsp_need_resend,
  input  logic [NUM_W-1:0]  rsp_displaced,
  input  logic              disp_hit,
  input  logic [IDX_W-1:0]  disp_idx,
  output logic [N_SRC-1:0]  want_clr,
  output logic [N_SRC-1:0]  want_disp,
  output logic [N_SRC-1:0]  rs_clr,
  output logic [N_SRC-1:0]  rs_set,
  output logic [N_SRC-1:0]  mp_set,
  output logic              rmap_set
);

  isr_state_e       st;
  logic [IDX_W-1:0] cur;
  logic [N_SRC-1:0] cur_oh;
  logic             srv_ok;
  logic             masked;
  logic             refused;
  logic             disp_take;

  assign rd_idx  = cur;
  assign cur_oh  = N_SRC'(1) << cur;
  assign srv_ok  = (rd_srv == SRV_W'(PRES_ID));
  assign masked  = (rd_prio == PRIO_W'(MASK_PRIO));
  assign refused = (st == ST_RSP) && rsp_valid && !rsp_ok;
  assign disp_take = (st == ST_RSP) && rsp_valid && rsp_ok && disp_hit &&
                     (rsp_displaced != NUM_W'(IPI_NUM)) && (rsp_displaced != '0);

  always_comb begin
    want_clr  = (st == ST_IDLE && pick_any) ? (N_SRC'(1) << pick_idx) : '0;
    rs_clr    = (st == ST_ATT) ? cur_oh : '0;
    mp_set    = (st == ST_ATT && srv_ok && masked) ? cur_oh : '0;
    rs_set    = refused ? cur_oh : '0;
    want_disp = disp_take ? (N_SRC'(1) << disp_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur       <= '0;
      dlv_valid <= 1'b0;
      dlv_num   <= '0;
      dlv_prio  <= '0;
      rmap_set  <= 1'b0;
    end else begin
      rmap_set <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (pick_any) begin
            cur <= pick_idx;
            st  <= ST_ATT;
          end
        end
        ST_ATT: begin
          if (!srv_ok || masked) begin
            st <= ST_IDLE;
          end else begin
            dlv_valid <= 1'b1;
            dlv_num   <= NUM_W'(SRC_BASE) + NUM_W'(cur);
            dlv_prio  <= rd_prio;
            st        <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (dlv_ready) begin
            dlv_valid <= 1'b0;
            st        <= ST_RSP;
          end
        end
        ST_RSP: begin
          if (rsp_valid) begin
            if (rsp_ok) begin
              st <= ST_IDLE;
            end else begin
              rmap_set <= 1'b1;
              st       <= rsp_need_resend ? ST_IDLE : ST_ATT;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R12: an offered request holds its content until taken
  assert_hold_offer_R12: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_num) && $stable(dlv_prio)));

  // R12: after a take, no new offer before a response is seen
  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_ready) |=> !dlv_valid);

  // R5: the resend-map strobe is one cycle wide and follows a refusal
  assert_rmap_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rmap_set |-> ($past(rsp_valid && !rsp_ok) && !$past(rmap_set)));

  // R3: a masked priority is never offered
  assert_no_masked_offer_R3: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (dlv_prio != PRIO_W'(MASK_PRIO)));

endmodule

// File: rtl/isr_resend_ctrl.sv
module isr_resend_ctrl #(
  parameter int N_SRC     = 16,
  parameter int PRIO_W    = 8,
  parameter int SRV_W     = 4,
  parameter int NUM_W     = 24,
  parameter int SRC_BASE  = 32,
  parameter int IPI_NUM   = 2,
  parameter int MASK_PRIO = 255,
  parameter int PRES_ID   = 0,
  localparam int IDX_W    = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic              lvl_we,
  input  logic [IDX_W-1:0]  lvl_idx,
  input  logic              lvl_on,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              scan_req,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [NUM_W-1:0]  dlv_num,
  output logic [PRIO_W-1:0] dlv_prio,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  input  logic              rsp_need_resend,
  input  logic [NUM_W-1:0]  rsp_displaced,
  output logic              rmap_set
);

  logic [N_SRC-1:0]  asserted, rs_q, mp_q, want_q;
  logic [N_SRC-1:0]  want_clr, want_disp, want_evt;
  logic [N_SRC-1:0]  rs_clr, rs_set, mp_set, mp_clr;
  logic [IDX_W-1:0]  rd_idx, pick_idx;
  logic [PRIO_W-1:0] rd_prio;
  logic [SRV_W-1:0]  rd_srv;
  logic              pick_any;
  logic              rej_hit, eoi_hit, disp_hit;
  logic [IDX_W-1:0]  rej_idx, eoi_idx, disp_idx;

  isr_src_table #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRV_W(SRV_W), .MASK_PRIO(MASK_PRIO)
  ) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_server(cfg_server),
    .lvl_we(lvl_we), .lvl_idx(lvl_idx), .lvl_on(lvl_on),
    .rd_idx(rd_idx), .rd_prio(rd_prio), .rd_srv(rd_srv), .asserted(asserted)
  );

  isr_num_dec #(.NUM_W(NUM_W), .N_SRC(N_SRC), .SRC_BASE(SRC_BASE)) u_dec_rej (
    .num(rej_num), .hit(rej_hit), .idx(rej_idx));
  isr_num_dec #(.NUM_W(NUM_W), .N_SRC(N_SRC), .SRC_BASE(SRC_BASE)) u_dec_eoi (
    .num(eoi_num), .hit(eoi_hit), .idx(eoi_idx));
  isr_num_dec #(.NUM_W(NUM_W), .N_SRC(N_SRC), .SRC_BASE(SRC_BASE)) u_dec_disp (
    .num(rsp_displaced), .hit(disp_hit), .idx(disp_idx));

  // Event decode: which sources ask for an attempt this cycle
  always_comb begin
    want_evt = '0;
    mp_clr   = '0;
    if (lvl_we && lvl_on) want_evt[lvl_idx] = 1'b1;
    if (cfg_we && (cfg_prio != PRIO_W'(MASK_PRIO)) && mp_q[cfg_idx]) begin
      want_evt[cfg_idx] = 1'b1;
      mp_clr[cfg_idx]   = 1'b1;
    end
    if (rej_valid && rej_hit) want_evt[rej_idx] = 1'b1;
    if (eoi_valid && (eoi_num != NUM_W'(IPI_NUM)) && eoi_hit && asserted[eoi_idx])
      want_evt[eoi_idx] = 1'b1;
    if (scan_req) want_evt = want_evt | rs_q;
    want_evt = want_evt | want_disp;
  end

  isr_flagvec #(.W(N_SRC)) u_want (
    .clk(clk), .rst(rst), .set_v(want_evt), .clr_v(want_clr), .q(want_q));
  isr_flagvec #(.W(N_SRC)) u_resend (
    .clk(clk), .rst(rst), .set_v(rs_set), .clr_v(rs_clr), .q(rs_q));
  isr_flagvec #(.W(N_SRC)) u_mpend (
    .clk(clk), .rst(rst), .set_v(mp_set), .clr_v(mp_clr), .q(mp_q));

  isr_pick #(.N_SRC(N_SRC)) u_pick (
    .clk(clk), .rst(rst), .req(want_q), .any(pick_any), .idx(pick_idx));

  isr_fsm #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRV_W(SRV_W), .NUM_W(NUM_W),
    .SRC_BASE(SRC_BASE), .IPI_NUM(IPI_NUM), .MASK_PRIO(MASK_PRIO), .PRES_ID(PRES_ID)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .pick_any(pick_any), .pick_idx(pick_idx),
    .rd_idx(rd_idx), .rd_prio(rd_prio), .rd_srv(rd_srv),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num), .dlv_prio(dlv_prio),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_need_resend(rsp_need_resend),
    .rsp_displaced(rsp_displaced), .disp_hit(disp_hit), .disp_idx(disp_idx),
    .want_clr(want_clr), .want_disp(want_disp),
    .rs_clr(rs_clr), .rs_set(rs_set), .mp_set(mp_set), .rmap_set(rmap_set)
  );

  // R4: an unmask with a parked event always raises a wait bit
  assert_unmask_wakes_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_prio != PRIO_W'(MASK_PRIO)) && mp_q[cfg_idx]) |=> want_q[$past(cfg_idx)]);

endmodule

// File: tb/tb_isr_resend_ctrl.sv
`timescale 1ns/1ps
module tb_isr_resend_ctrl;

  localparam int NUM_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             cfg_we = 0, lvl_we = 0, lvl_on = 0;
  logic [3:0]       cfg_idx = 0, lvl_idx = 0, cfg_server = 0;
  logic [7:0]       cfg_prio = 0;
  logic             rej_valid = 0, eoi_valid = 0, scan_req = 0;
  logic [NUM_W-1:0] rej_num = 0, eoi_num = 0, rsp_displaced = 0;
  logic             dlv_ready = 0, rsp_valid = 0, rsp_ok = 0, rsp_need_resend = 0;
  logic             dlv_valid, rmap_set;
  logic [NUM_W-1:0] dlv_num;
  logic [7:0]       dlv_prio;

  isr_resend_ctrl dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_server(cfg_server),
    .lvl_we(lvl_we), .lvl_idx(lvl_idx), .lvl_on(lvl_on),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .scan_req(scan_req),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num), .dlv_prio(dlv_prio),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_need_resend(rsp_need_resend),
    .rsp_displaced(rsp_displaced), .rmap_set(rmap_set)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected below 20000", cyc);
      report();
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_cfg(input int idx, input int prio, input int srv);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_prio = 8'(prio); cfg_server = 4'(srv);
    tick();
    cfg_we = 0;
  endtask

  task automatic do_lvl(input int idx, input logic on);
    lvl_we = 1; lvl_idx = 4'(idx); lvl_on = on;
    tick();
    lvl_we = 0;
  endtask

  task automatic do_rej(input int num);
    rej_valid = 1; rej_num = NUM_W'(num);
    tick();
    rej_valid = 0;
  endtask

  task automatic do_eoi(input int num);
    eoi_valid = 1; eoi_num = NUM_W'(num);
    tick();
    eoi_valid = 0;
  endtask

  task automatic do_scan();
    scan_req = 1;
    tick();
    scan_req = 0;
  endtask

  // request expected on the given edge counted after the last sampled stimulus
  task automatic expect_req(input int edges, input int num, input int prio, input string tag);
    for (int k = 1; k < edges; k++) begin
      tick();
      chk({tag, " early"}, 32'(dlv_valid), 32'd0);
    end
    tick();
    chk({tag, " valid"}, 32'(dlv_valid), 32'd1);
    chk({tag, " num"}, 32'(dlv_num), 32'(num));
    chk({tag, " prio"}, 32'(dlv_prio), 32'(prio));
  endtask

  task automatic quiet(input int n, input string tag);
    logic seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (dlv_valid) seen = 1'b1;
    end
    chk({tag, " no request"}, 32'(seen), 32'd0);
  endtask

  task automatic serve(input logic ok, input logic need, input int disp, input string tag);
    dlv_ready = 1;
    tick();
    dlv_ready = 0;
    chk({tag, " R12 taken"}, 32'(dlv_valid), 32'd0);
    rsp_valid = 1; rsp_ok = ok; rsp_need_resend = need; rsp_displaced = NUM_W'(disp);
    tick();
    rsp_valid = 0; rsp_displaced = '0;
    chk({tag, " R5 rmap"}, 32'(rmap_set), 32'(!ok));
  endtask

  task automatic t_reset();
    chk("R1 dlv_valid", 32'(dlv_valid), 32'd0);
    chk("R1 rmap_set", 32'(rmap_set), 32'd0);
    do_lvl(0, 1'b1);
    quiet(4, "R1 masked after reset");
    do_lvl(0, 1'b0);
  endtask

  task automatic t_basic();
    do_cfg(3, 5, 0);
    quiet(3, "R2 cfg alone");
    do_lvl(3, 1'b1);
    expect_req(2, 35, 5, "R2 first delivery");
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R12 hold valid", 32'(dlv_valid), 32'd1);
      chk("R12 hold num", 32'(dlv_num), 32'd35);
    end
    serve(1'b1, 1'b0, 0, "R2");
    quiet(3, "R12 done");
  endtask

  task automatic t_mask();
    do_lvl(4, 1'b1);
    quiet(4, "R3 masked source");
    do_cfg(4, 7, 0);
    expect_req(2, 36, 7, "R4 unmask delivers");
    serve(1'b1, 1'b0, 0, "R4");
    do_cfg(5, 9, 0);
    quiet(4, "R4 unmask without pending");
  endtask

  task automatic t_refuse();
    do_lvl(3, 1'b1);
    expect_req(2, 35, 5, "R5 offer");
    serve(1'b0, 1'b1, 0, "R5 refuse");
    tick();
    chk("R5 rmap one cycle", 32'(rmap_set), 32'd0);
    quiet(3, "R6 need_resend set no retry");
    do_scan();
    expect_req(2, 35, 5, "R9 scan redelivers");
    serve(1'b1, 1'b0, 0, "R9");
    do_scan();
    quiet(4, "R9 flag cleared");
    do_lvl(3, 1'b1);
    expect_req(2, 35, 5, "R6 offer");
    serve(1'b0, 1'b0, 0, "R6 refuse");
    expect_req(1, 35, 5, "R6 immediate retry");
    serve(1'b1, 1'b0, 0, "R6");
    do_scan();
    quiet(4, "R9 retry cleared flag");
  endtask

  task automatic t_displace();
    do_cfg(6, 3, 0);
    do_lvl(6, 1'b1);
    expect_req(2, 38, 3, "R7 offer");
    serve(1'b1, 1'b0, 35, "R7 displace src3");
    expect_req(2, 35, 5, "R7 displaced redelivered");
    serve(1'b1, 1'b0, 2, "R7 displace ipi");
    quiet(4, "R7 ipi displaced");
    do_lvl(6, 1'b1);
    expect_req(2, 38, 3, "R7 offer2");
    serve(1'b1, 1'b0, 999, "R7 displace foreign");
    quiet(4, "R7 foreign displaced");
  endtask

  task automatic t_reject();
    do_rej(38);
    expect_req(2, 38, 3, "R8 reject redelivers");
    serve(1'b1, 1'b0, 0, "R8");
    do_rej(500);
    quiet(4, "R8 foreign reject");
  endtask

  task automatic t_scan_order();
    do_cfg(9, 2, 0);
    do_lvl(9, 1'b1);
    expect_req(2, 41, 2, "R9 setup9");
    serve(1'b0, 1'b1, 0, "R9 setup9");
    do_cfg(2, 1, 0);
    do_lvl(2, 1'b1);
    expect_req(2, 34, 1, "R9 setup2");
    serve(1'b0, 1'b1, 0, "R9 setup2");
    do_cfg(12, 3, 0);
    do_lvl(12, 1'b1);
    expect_req(2, 44, 3, "R9 setup12");
    serve(1'b0, 1'b1, 0, "R9 setup12");
    do_scan();
    expect_req(2, 34, 1, "R9 order first");
    serve(1'b1, 1'b0, 0, "R9 a");
    expect_req(2, 41, 2, "R9 order second");
    serve(1'b1, 1'b0, 0, "R9 b");
    expect_req(2, 44, 3, "R9 order third");
    serve(1'b1, 1'b0, 0, "R9 c");
    quiet(4, "R9 order end");
  endtask

  task automatic t_masked_resend();
    do_cfg(10, 4, 0);
    do_lvl(10, 1'b1);
    expect_req(2, 42, 4, "R3 setup");
    serve(1'b0, 1'b1, 0, "R3 setup");
    do_cfg(10, 255, 0);
    do_scan();
    quiet(4, "R3 resend while masked");
    do_cfg(10, 4, 0);
    expect_req(2, 42, 4, "R3 parked resend surfaces");
    serve(1'b1, 1'b0, 0, "R3");
  endtask

  task automatic t_eoi();
    do_eoi(35);
    expect_req(2, 35, 5, "R10 still asserted");
    serve(1'b1, 1'b0, 0, "R10");
    do_lvl(3, 1'b0);
    do_eoi(35);
    quiet(4, "R10 deasserted");
    do_eoi(2);
    quiet(4, "R10 ipi ignored");
  endtask

  task automatic t_server();
    do_cfg(7, 2, 5);
    do_lvl(7, 1'b1);
    quiet(4, "R11 foreign server");
    do_cfg(7, 2, 0);
    quiet(3, "R11 no parked event");
    do_lvl(7, 1'b1);
    expect_req(2, 39, 2, "R11 local server");
    serve(1'b1, 1'b0, 0, "R11");
  endtask

  task automatic t_lowest();
    do_cfg(1, 6, 0);
    do_cfg(8, 1, 0);
    lvl_we = 1; lvl_idx = 4'd8; lvl_on = 1;
    rej_valid = 1; rej_num = NUM_W'(33);
    tick();
    lvl_we = 0; rej_valid = 0;
    expect_req(2, 33, 6, "R13 lowest first");
    serve(1'b1, 1'b0, 0, "R13 a");
    expect_req(2, 40, 1, "R13 then next");
    serve(1'b1, 1'b0, 0, "R13 b");
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_basic();
    t_mask();
    t_refuse();
    t_displace();
    t_reject();
    t_scan_order();
    t_masked_resend();
    t_eoi();
    t_server();
    t_lowest();
    repeat (4) tick();
    report();
  end

endmodule